// File: doc/BRIEF.md
# DMA Command Completion Event Counter

This block is the per-channel interrupt bookkeeping register of a descriptor-list DMA engine. The channel engine pulses an event input once when a command list has been loaded and once more for each command that completes afterwards. Every pulse advances a hardware-owned 6-bit done count. Software owns a 6-bit processed count. It acknowledges work by writing the done value it last read into the processed field. The difference between the two counts, taken modulo 64, is the number of events software has not yet handled. A level interrupt stays high while that difference is non-zero.

Acknowledging by copying a counter, instead of clearing a sticky flag, lets several completions accumulate between interrupt services. The counters wrap without loss as long as fewer than 64 events are outstanding. The done count never changes through the register port, so an event that lands in the same cycle as an acknowledge still counts and keeps the line high.

A sticky active flag records that at least one event occurred. Software clears it by writing zero to its bit. The interrupt is gated by three enable bits taken from the channel's general configuration: list interrupt, interrupt enable and level mode.

Top module: `dma_evt_ctr`

## Requirements
- R1: After reset the read word is zero (both counts and the active flag clear) and `irq_o` is low.
- R2: Each cycle with `evt_i` high advances the done count (read bits [5:0]) by one modulo 64, so 63 is followed by 0. Without `evt_i` it holds.
- R3: A register write has no effect on the done count, whatever value it carries in bits [5:0].
- R4: A register write loads the processed count (read bits [21:16]) from write-data bits [21:16]. Without a write it holds.
- R5: When `evt_i` and a write occur in the same cycle, the done count still takes the increment and the processed count takes the written value.
- R6: The active flag (read bit 8) is set by every event. A write with data bit 8 at 0 clears it. A write with bit 8 at 1 leaves it unchanged. An event in the same cycle as a clearing write leaves it set.
- R7: With all three bits of `irq_cfg_i` high, `irq_o` in a cycle is high exactly when, in the previous cycle, done differed from processed. It therefore falls in the cycle after the counts become equal.
- R8: If any bit of `irq_cfg_i` (bit 2 list interrupt, bit 1 interrupt enable, bit 0 level mode) was low in the previous cycle, `irq_o` is low.
- R9: Up to 63 unacknowledged events accumulate: (done − processed) mod 64 equals the number of events since the last acknowledge.
- R10: Read bits [31:22], [15:9] and [7:6] are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Single-cycle event pulse from the channel engine |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| irq_cfg_i | input | 3 | Enables: [2] list interrupt, [1] interrupt enable, [0] level mode |
| rdata_o | output | 32 | Register read value |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the count stepping and holding, the loading of the processed field, the setting of the active flag, interrupt gating by the enables, the one-cycle relation between unequal counts and the interrupt, and the zero reserved bits. Some behaviours only the bench scenarios can show. These are a full 63-event backlog and the wrap that follows it, a collision of an event with an acknowledge that must not drop the event, and the read-modify-acknowledge sequence software actually performs. A behavioural model compares the full read word and the interrupt each cycle, including during a long stretch of random event and write traffic.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int unsigned DONE_LSB = 0;
  localparam int unsigned ACT_BIT  = 8;
  localparam int unsigned PROC_LSB = 16;
  localparam int unsigned CFG_W    = 3;
endpackage

// File: rtl/dma_evt_done_ctr.sv
module dma_evt_done_ctr #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // wraps naturally at 2**CNT_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (evt_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_evt_ack_reg.sv
module dma_evt_ack_reg #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_proc_i,
  input  logic             wr_act_i,
  output logic [CNT_W-1:0] proc_o,
  output logic             act_o
);
  logic [CNT_W-1:0] proc_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   proc_q <= '0;
    else if (wr_i) proc_q <= wr_proc_i;
  end

  // event wins over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  act_q <= 1'b0;
    else if (evt_i)               act_q <= 1'b1;
    else if (wr_i && !wr_act_i)   act_q <= 1'b0;
  end

  assign proc_o = proc_q;
  assign act_o  = act_q;
endmodule

// File: rtl/dma_evt_irq_gen.sv
module dma_evt_irq_gen #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned CFG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [CNT_W-1:0] done_i,
  input  logic [CNT_W-1:0] proc_i,
  output logic             irq_o
);
  logic pending;
  logic irq_q;

  assign pending = (done_i != proc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (&cfg_i) & pending;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_evt_ctr.sv
module dma_evt_ctr
  import dma_evt_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CFG_W-1:0]  irq_cfg_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PROC_MSB = PROC_LSB + CNT_W - 1;
  localparam int unsigned DONE_MSB = DONE_LSB + CNT_W - 1;

  logic [CNT_W-1:0] done_cnt;
  logic [CNT_W-1:0] proc_cnt;
  logic             act_flag;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  dma_evt_done_ctr #(.CNT_W(CNT_W)) u_done (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .cnt_o (done_cnt)
  );

  dma_evt_ack_reg #(.CNT_W(CNT_W)) u_ack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .wr_i     (wr_i),
    .wr_proc_i(wdata_i[PROC_MSB:PROC_LSB]),
    .wr_act_i (wdata_i[ACT_BIT]),
    .proc_o   (proc_cnt),
    .act_o    (act_flag)
  );

  dma_evt_irq_gen #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cfg_i (irq_cfg_i),
    .done_i(done_cnt),
    .proc_i(proc_cnt),
    .irq_o (irq_o)
  );

  // readback word, one bit at a time by field position
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b >= DONE_LSB && b <= DONE_MSB) begin : g_done
      assign rdata_o[b] = done_cnt[b-DONE_LSB];
    end else if (b >= PROC_LSB && b <= PROC_MSB) begin : g_proc
      assign rdata_o[b] = proc_cnt[b-PROC_LSB];
    end else if (b == ACT_BIT) begin : g_act
      assign rdata_o[b] = act_flag;
    end else begin : g_zero
      assign rdata_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/dma_evt_ctr_chk.sv
module dma_evt_ctr_chk
  import dma_evt_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CFG_W-1:0]  irq_cfg_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o
);
  logic [CNT_W-1:0] done_f, proc_f, wproc_f;
  logic             act_f;
  logic             unused_chk;

  assign done_f     = rdata_o[DONE_LSB +: CNT_W];
  assign proc_f     = rdata_o[PROC_LSB +: CNT_W];
  assign act_f      = rdata_o[ACT_BIT];
  assign wproc_f    = wdata_i[PROC_LSB +: CNT_W];
  assign unused_chk = ^wdata_i;

  AST_DONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> done_f == $past(done_f) + 1'b1);                    // R2
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(done_f));                                   // R3
  AST_PROC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> proc_f == $past(wproc_f));                            // R4
  AST_PROC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(proc_f));                                    // R4
  AST_ACT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> act_f);                                              // R6
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&irq_cfg_i) |=> !irq_o);                                     // R8
  AST_IRQ_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&irq_cfg_i) && done_f != proc_f) |=> irq_o);                 // R7
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_f == proc_f) |=> !irq_o);                                // R7
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:PROC_LSB+CNT_W] == '0 &&
    rdata_o[PROC_LSB-1:ACT_BIT+1] == '0 &&
    rdata_o[ACT_BIT-1:DONE_LSB+CNT_W] == '0);                      // R10
endmodule

bind dma_evt_ctr dma_evt_ctr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .irq_cfg_i(irq_cfg_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o)
);

// File: tb/tb_dma_evt_ctr.sv
module tb_dma_evt_ctr;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [2:0]  irq_cfg_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_done = 0, m_proc = 0, m_act = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_evt_ctr dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .irq_cfg_i(irq_cfg_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(int'(rdata_o[5:0]) == m_done, "R2 done field", int'(rdata_o[5:0]), m_done);
    check(int'(rdata_o[21:16]) == m_proc, "R4 processed field", int'(rdata_o[21:16]), m_proc);
    check(int'(rdata_o[8]) == m_act, "R6 active flag", int'(rdata_o[8]), m_act);
    check(int'(irq_o) == m_irq, "R7 irq level", int'(irq_o), m_irq);
    check((rdata_o & 32'hFFC0_FEC0) == 0, "R10 reserved bits", int'(rdata_o), 0);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit e, input bit w, input logic [31:0] d);
    int nd, np, na, ni;
    evt_i = e; wr_i = w; wdata_i = d;
    @(posedge clk_i);
    ni = ((irq_cfg_i == 3'b111) && (m_done != m_proc)) ? 1 : 0;
    nd = e ? (m_done + 1) % 64 : m_done;
    np = w ? int'(d[21:16]) : m_proc;
    na = e ? 1 : ((w && !d[8]) ? 0 : m_act);
    m_done = nd; m_proc = np; m_act = na; m_irq = ni;
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic ack();
    logic [31:0] d;
    d = {10'd0, rdata_o[5:0], 16'd0};
    step(1'b0, 1'b1, d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check(rdata_o == 0, "R1 reset word", int'(rdata_o), 0);
    check(irq_o == 1'b0, "R1 reset irq", int'(irq_o), 0);

    irq_cfg_i = 3'b111;
    step(0, 0, 0);
    repeat (3) step(1, 0, 0);
    step(0, 0, 0);
    check(irq_o == 1'b1, "R7 irq high with 3 pending", int'(irq_o), 1);

    // write tries to set done to 0x3F, processed to 3, clears active
    step(0, 1, 32'h0003_003F);
    check(int'(rdata_o[5:0]) == 3, "R3 done unchanged by write", int'(rdata_o[5:0]), 3);
    check(rdata_o[8] == 1'b0, "R6 active cleared", int'(rdata_o[8]), 0);
    step(0, 0, 0);
    check(irq_o == 1'b0, "R7 irq drops after equal", int'(irq_o), 0);

    // collision: event and acknowledge together
    step(1, 1, 32'h0003_0000);
    check(int'(rdata_o[5:0]) == 4, "R5 done increments on collision", int'(rdata_o[5:0]), 4);
    check(int'(rdata_o[21:16]) == 3, "R5 processed takes write", int'(rdata_o[21:16]), 3);
    check(rdata_o[8] == 1'b1, "R6 event beats clearing write", int'(rdata_o[8]), 1);
    step(0, 0, 0);
    check(irq_o == 1'b1, "R5 collision event not lost", int'(irq_o), 1);

    step(0, 1, 32'h0003_0100);
    check(rdata_o[8] == 1'b1, "R6 write bit8=1 keeps active", int'(rdata_o[8]), 1);

    // enable gating, one bit at a time
    for (int k = 0; k < 3; k++) begin
      irq_cfg_i = 3'b111 & ~(3'b001 << k);
      step(0, 0, 0);
      step(0, 0, 0);
      check(irq_o == 1'b0, "R8 irq gated by enable bit", int'(irq_o), 0);
    end
    irq_cfg_i = 3'b111;
    step(0, 0, 0);

    // backlog of 63 then wrap to equal
    ack();
    repeat (63) step(1, 0, 0);
    check(((int'(rdata_o[5:0]) - int'(rdata_o[21:16])) & 63) == 63,
          "R9 63 pending", (int'(rdata_o[5:0]) - int'(rdata_o[21:16])) & 63, 63);
    step(0, 0, 0);
    check(irq_o == 1'b1, "R9 irq with full backlog", int'(irq_o), 1);
    step(1, 0, 0);
    step(0, 0, 0);
    check(irq_o == 1'b0, "R2 wrap to equal drops irq", int'(irq_o), 0);

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (($urandom % 16) == 0) irq_cfg_i = 3'($urandom);
      step(r[31], r[30] & r[29], {10'd0, r[21:16], 7'd0, r[8], 2'd0, r[5:0]});
    end

    finish_run();
  end
endmodule